// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link made of a shift clock, a data-out line and a data-in line. A transfer begins when the host pulses `start` while the port is idle. The byte on `tx_byte` and the configuration inputs are captured at that moment. The port then shifts the data and raises `done` once the last bit is in. The assembled input byte is presented on `rx_byte`.

The configuration selects three things:
- whether the port both sends and receives, or only receives;
- whether bit 0 or bit 7 travels first;
- whether the port produces the shift clock itself or follows a clock from a remote master.

The internal clock comes from a programmable divider of the system clock. A remote clock is brought into the system clock domain through a two-flop synchronizer, and the input data goes through a matching synchronizer. The input line is sampled when the shift clock rises. The output line changes only when the shift clock falls. The shift clock idles high.

Top module: `sio_port`

## Requirements
- R1: After reset `busy`=0, `done`=0, `sck_o`=1, `sdo`=1 and `rx_byte`=0. With `cfg_ext_clk`=0, `sck_oe`=1.
- R2: `start` while idle captures `tx_byte` and the configuration, sets `busy` and clears `done` on that clock edge. `start` while `busy` is ignored: the transfer keeps its data and its length.
- R3: Every transfer has exactly BITS (8) rising shift-clock edges. The edge on which the last bit is sampled clears `busy` and sets `done`. `sck_o` is 1 whenever `busy` is 0.
- R4: With the internal clock, each half period of `sck_o` lasts `cfg_div`+1 system clocks. `done` goes high 16·(`cfg_div`+1) clock edges after the edge that sampled `start`.
- R5: During a transfer, `sdo` changes only on a falling shift-clock edge. The first bit is on `sdo` from the start edge onward.
- R6: `sdi` is sampled on rising shift-clock edges. With `cfg_lsb_first`=0 the first sampled bit lands in `rx_byte[7]`; with `cfg_lsb_first`=1 it lands in `rx_byte[0]`. `rx_byte` changes only when a transfer completes.
- R7: With `cfg_lsb_first`=1, `sdo` sends `tx_byte[0]` first and `tx_byte[7]` last. With `cfg_lsb_first`=0 the order is reversed.
- R8: With `cfg_rx_only`=1, `sdo` stays 1 for the whole transfer while reception works normally.
- R9: With `cfg_ext_clk`=1, `sck_oe`=0 and the bits are shifted by edges of `sck_i` after synchronization. Edges on `sck_i` while idle do not start or change anything.
- R10: Changes to the configuration inputs during a transfer have no effect on that transfer.
- R11: `done` stays 1 and `rx_byte` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| tx_byte | input | BITS | Byte to send |
| cfg_rx_only | input | 1 | 1: receive only, data-out held high |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfg_ext_clk | input | 1 | 1: shift clock from `sck_i`; 0: internal divider |
| cfg_div | input | DIV_W | Internal half-period minus one, in system clocks |
| sck_i | input | 1 | Shift clock from a remote master |
| sck_o | output | 1 | Generated shift clock (idles high) |
| sck_oe | output | 1 | Enable for driving the clock pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion flag / interrupt request |
| rx_byte | output | BITS | Last byte received |

## Verification
The bench acts as a slave when the port drives the clock and as a master when it does not. Each transfer carries one byte out and a different byte in, so a swapped bit order, a lost bit or an extra bit shows up as a mismatched byte on either side.

Directed cases cover:
- the shortest and longer divider settings, which separate half-period errors from bit-count errors;
- a start pulse during a transfer;
- configuration flips during a transfer;
- receive-only mode;
- idle toggling of the remote clock.

Seeded random transfers then mix all modes, orders, dividers and data patterns.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef struct packed {
      logic rx_only;
      logic lsb_first;
      logic ext_clk;
   } sio_cfg_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sio_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] half_cnt;
   logic             wrap;

   assign wrap = run && (half_cnt == div);
   assign rise = wrap && !sck;
   assign fall = wrap && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         sck      <= 1'b1;
      end else if (!run) begin
         half_cnt <= '0;
         sck      <= 1'b1;
      end else if (wrap) begin
         half_cnt <= '0;
         sck      <= ~sck;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] load_val,
   input  logic            lsb_first,
   input  logic            rise,
   input  logic            fall,
   input  logic            din,
   output logic            dout,
   output logic [BITS-1:0] rx_next,
   output logic            last
);
   localparam int CNT_W = $clog2(BITS + 1);

   logic [BITS-1:0]  tx_sr;
   logic [BITS-1:0]  rx_sr;
   logic [CNT_W-1:0] bit_cnt;

   assign dout = lsb_first ? tx_sr[0] : tx_sr[BITS-1];
   assign last = rise && (bit_cnt == CNT_W'(BITS - 1));

   always_comb begin
      if (lsb_first) rx_next = {din, rx_sr[BITS-1:1]};
      else           rx_next = {rx_sr[BITS-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_cnt <= '0;
      end else if (load) begin
         tx_sr   <= load_val;
         rx_sr   <= '0;
         bit_cnt <= '0;
      end else begin
         if (rise) begin
            rx_sr   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (fall && bit_cnt != '0) begin
            if (lsb_first) tx_sr <= {1'b0, tx_sr[BITS-1:1]};
            else           tx_sr <= {tx_sr[BITS-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/sio_port.sv
module sio_port #(
   parameter int BITS        = 8,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BITS-1:0]  tx_byte,
   input  logic             cfg_rx_only,
   input  logic             cfg_lsb_first,
   input  logic             cfg_ext_clk,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             sck_i,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             sdo,
   input  logic             sdi,
   output logic             busy,
   output logic             done,
   output logic [BITS-1:0]  rx_byte
);
   import sio_pkg::*;

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("sio_port BITS must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("sio_port DIV_W out of range");
      end
   endgenerate

   sio_cfg_t         cfg_q;
   logic [DIV_W-1:0] div_q;
   logic             rxo_q, ext_q, lsb_q;
   logic             accept;
   logic             sck_s, sck_prev, sdi_s, sdi_eff;
   logic             int_rise, int_fall, ext_rise, ext_fall;
   logic             rise_e, fall_e, last;
   logic             tx_bit;
   logic [BITS-1:0]  rx_next;

   assign rxo_q  = cfg_q.rx_only;
   assign ext_q  = cfg_q.ext_clk;
   assign lsb_q  = cfg_q.lsb_first;
   assign accept = start && !busy;

   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdi_sync (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b1;
      else        sck_prev <= sck_s;
   end

   assign ext_rise = sck_s && !sck_prev;
   assign ext_fall = !sck_s && sck_prev;

   sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy && !ext_q), .div(div_q),
      .sck(sck_o), .rise(int_rise), .fall(int_fall));

   assign rise_e  = busy && (ext_q ? ext_rise : int_rise);
   assign fall_e  = busy && (ext_q ? ext_fall : int_fall);
   assign sdi_eff = ext_q ? sdi_s : sdi;

   sio_shifter #(.BITS(BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tx_byte),
      .lsb_first(lsb_q), .rise(rise_e), .fall(fall_e), .din(sdi_eff),
      .dout(tx_bit), .rx_next(rx_next), .last(last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         div_q   <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx_byte <= '0;
      end else if (accept) begin
         cfg_q   <= '{rx_only: cfg_rx_only, lsb_first: cfg_lsb_first, ext_clk: cfg_ext_clk};
         div_q   <= cfg_div;
         busy    <= 1'b1;
         done    <= 1'b0;
      end else if (last) begin
         busy    <= 1'b0;
         done    <= 1'b1;
         rx_byte <= rx_next;
      end
   end

   assign sdo    = (busy && !rxo_q) ? tx_bit : 1'b1;
   assign sck_oe = !(busy ? ext_q : cfg_ext_clk);
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
   parameter int BITS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            sck_o,
   input logic            sck_oe,
   input logic            sdo,
   input logic [BITS-1:0] rx_byte,
   input logic            rxo_q,
   input logic            ext_q,
   input logic            last,
   input logic            fall_e
);
   assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o);
   assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));
   assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !last |=> busy);
   assert_sdo_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(fall_e) |-> $stable(sdo));
   assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(rx_byte));
   assert_rxonly_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rxo_q |-> sdo);
   assert_ext_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ext_q |-> !sck_oe);
   assert_done_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
endmodule

bind sio_port sio_port_chk #(.BITS(BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .rx_byte(rx_byte),
   .rxo_q(rxo_q), .ext_q(ext_q), .last(last), .fall_e(fall_e));

// File: tb/sio_port_bench.sv
`timescale 1ns/1ps
module sio_port_bench;
   localparam int BITS  = 8;
   localparam int DIV_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [BITS-1:0]  tx_byte = '0;
   logic             cfg_rx_only = 1'b0, cfg_lsb_first = 1'b0, cfg_ext_clk = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic             sck_i = 1'b1, sdi = 1'b1;
   logic             sck_o, sck_oe, sdo, busy, done;
   logic [BITS-1:0]  rx_byte;

   int n_vec = 0, n_bad = 0;

   always #2 clk = ~clk;

   sio_port #(.BITS(BITS), .DIV_W(DIV_W)) u_sio_port (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
      .cfg_rx_only(cfg_rx_only), .cfg_lsb_first(cfg_lsb_first),
      .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div), .sck_i(sck_i),
      .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi),
      .busy(busy), .done(done), .rx_byte(rx_byte));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int pos(input int i, input bit lsb);
      return lsb ? i : BITS - 1 - i;
   endfunction

   function automatic int xfer_len(input int div);
      return 16 * (div + 1) + 1;
   endfunction

   task automatic xfer_int(input logic [7:0] tx, input logic [7:0] rxp, input bit lsb,
                           input bit rxo, input int div, input bit poke, input bit flip);
      int n = 0, rises = 0;
      bit prev_sck = 1'b1, prev_sdo = 1'b1, cur = 1'b1, sdo_ok = 1'b1, rxo_ok = 1'b1;
      logic [7:0] got = '0;
      @(negedge clk);
      cfg_ext_clk = 0; cfg_lsb_first = lsb; cfg_rx_only = rxo;
      cfg_div = DIV_W'(div); tx_byte = tx; sdi = rxp[pos(0, lsb)]; start = 1;
      do begin
         @(negedge clk); n++;
         if (n == 1) begin
            start = 0;
            chk(busy === 1'b1 && done === 1'b0, "R2 start accept", {busy, done}, 2);
            if (flip) begin cfg_lsb_first = ~lsb; cfg_rx_only = ~rxo; cfg_div = ~cfg_div; end
         end
         if (poke && n == 5) begin start = 1; tx_byte = ~tx; end
         if (poke && n == 6) start = 0;
         if (!sck_o) cur = sdo;
         if (!prev_sck && sck_o) begin
            if (rises < 8) got[pos(rises, lsb)] = cur;
            rises++;
         end
         if (prev_sck && !sck_o && rises >= 1 && rises < 8) sdi = rxp[pos(rises, lsb)];
         if (n > 1 && !done && sdo !== prev_sdo && !(prev_sck && !sck_o)) sdo_ok = 0;
         if (rxo && sdo !== 1'b1) rxo_ok = 0;
         prev_sck = sck_o; prev_sdo = sdo;
      end while (!done && n < 4000);
      chk(n == xfer_len(div), poke ? "R2 R4 length" : (flip ? "R10 R4 length" : "R4 length"),
          n, xfer_len(div));
      chk(rises == 8 && busy === 1'b0 && sck_o === 1'b1, "R3 edge count", rises, 8);
      chk(rx_byte === rxp, flip ? "R10 R6 rx byte" : "R6 rx byte", rx_byte, rxp);
      if (!rxo) chk(got === tx, poke ? "R2 R7 tx byte" : "R7 tx byte", got, tx);
      else      chk(rxo_ok, "R8 sdo quiet", 0, 1);
      chk(sdo_ok, "R5 sdo change on fall", 0, 1);
   endtask

   task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] rxp, input bit lsb,
                           input bit rxo, input bit idle_tog);
      logic [7:0] got = '0;
      logic [7:0] rx_before;
      bit rxo_ok = 1'b1;
      @(negedge clk);
      cfg_ext_clk = 1; cfg_lsb_first = lsb; cfg_rx_only = rxo; tx_byte = tx;
      sck_i = 1; sdi = rxp[pos(0, lsb)];
      if (idle_tog) begin
         rx_before = rx_byte;
         for (int k = 0; k < 3; k++) begin
            sck_i = 0; repeat (4) @(negedge clk);
            sck_i = 1; repeat (4) @(negedge clk);
         end
         chk(busy === 1'b0 && rx_byte === rx_before, "R9 idle edges ignored", busy, 0);
      end
      repeat (4) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      chk(busy === 1'b1 && sck_oe === 1'b0 && done === 1'b0, "R9 clock pin released",
          {busy, sck_oe, done}, 4);
      for (int i = 0; i < 8; i++) begin
         sdi = rxp[pos(i, lsb)]; sck_i = 0;
         repeat (8) begin
            @(negedge clk);
            if (rxo && sdo !== 1'b1) rxo_ok = 0;
         end
         got[pos(i, lsb)] = sdo;
         sck_i = 1;
         repeat (8) @(negedge clk);
      end
      chk(done === 1'b1 && busy === 1'b0, "R9 R3 ext done", {done, busy}, 2);
      chk(rx_byte === rxp, "R9 R6 ext rx byte", rx_byte, rxp);
      if (!rxo) chk(got === tx, "R9 R7 ext tx byte", got, tx);
      else      chk(rxo_ok, "R8 ext sdo quiet", 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'h5107));
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && sck_o === 1 && sdo === 1 && rx_byte === 0 && sck_oe === 1,
          "R1 reset state", {busy, done, sck_o, sdo, sck_oe}, 6'b00111);
      rst_n = 1;
      repeat (2) @(negedge clk);

      xfer_int(8'hA5, 8'h3C, 1'b0, 1'b0, 0, 1'b0, 1'b0);
      xfer_int(8'h81, 8'hC2, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      xfer_int(8'h6E, 8'h17, 1'b0, 1'b0, 3, 1'b0, 1'b0);
      xfer_int(8'hF0, 8'h0F, 1'b1, 1'b0, 15, 1'b0, 1'b0);
      xfer_int(8'h5A, 8'h99, 1'b0, 1'b0, 1, 1'b1, 1'b0);
      xfer_int(8'hC3, 8'h2D, 1'b1, 1'b0, 2, 1'b0, 1'b1);
      xfer_int(8'h00, 8'hB6, 1'b0, 1'b1, 1, 1'b0, 1'b0);

      held = rx_byte;
      repeat (20) @(negedge clk);
      chk(done === 1'b1 && rx_byte === held, "R11 done held", {done, rx_byte}, {1'b1, held});

      xfer_ext(8'h93, 8'h4E, 1'b0, 1'b0, 1'b1);
      xfer_ext(8'h1B, 8'hE4, 1'b1, 1'b1, 1'b0);

      for (int r = 0; r < 24; r++) begin
         logic [7:0] tx, rxp;
         bit lsb, rxo;
         tx  = 8'($urandom);
         rxp = 8'($urandom);
         lsb = 1'($urandom);
         rxo = ($urandom % 4) == 0;
         if (($urandom % 3) == 0) xfer_ext(tx, rxp, lsb, rxo, 1'($urandom));
         else xfer_int(tx, rxp, lsb, rxo, int'($urandom % 4), 1'b0, 1'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule